// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This combinational block forms the second operand of a 32-bit data-processing datapath and the shifter carry that goes with it. It takes one of three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register value shifted by a 5-bit amount held in the instruction. The third is a register value shifted by an amount taken from the low byte of another register. The block returns the shifted operand and the carry-out. The ALU consumes the operand. The flag logic decides whether to keep the carry.

The shift amount zero carries special meanings. In the immediate-shift form it stands for a shift by 32 or for a one-bit rotate through the carry. In the register form it means that no shift takes place. Register amounts past the word width are clamped so that every result and every carry is well defined. The caller reads the registers and supplies only the low byte of the amount register.

Top module: `bs_operand_shifter`

## Requirements
- R1: `opd_form` selects the operand form: 0 is the rotated immediate, 1 is the register shifted by an immediate amount, and 2 is the register shifted by a register amount. `shift_kind` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right.
- R2: In form 0, `imm_byte` is zero-extended to 32 bits and rotated right by twice `rot_field`. If `rot_field` is 0, the operand is the zero-extended byte and `carry_out` equals `carry_in`. Otherwise `carry_out` equals bit 31 of the operand.
- R3: In form 1 with logical left and `imm_amt` of 0, the operand equals `reg_val` and `carry_out` equals `carry_in`.
- R4: In form 1, logical right or arithmetic right with `imm_amt` of 0 acts as a shift by 32.
- R5: In form 1, rotate right with `imm_amt` of 0 shifts `reg_val` right by one bit. `carry_in` enters bit 31 and `reg_val` bit 0 becomes `carry_out`.
- R6: In form 2, an `amt_byte` of 0 leaves the operand equal to `reg_val` and `carry_out` equal to `carry_in`, for every shift kind.
- R7: In form 2, logical shifts by exactly 32 give an operand of 0. The carry is `reg_val` bit 0 for a left shift and bit 31 for a right shift. Amounts of 33 to 255 give an operand of 0 and a carry of 0.
- R8: In form 2, arithmetic right by 32 or more fills every operand bit with `reg_val` bit 31, and `carry_out` also equals bit 31.
- R9: In form 2, rotate right uses the low five bits of `amt_byte`. A nonzero amount whose low five bits are zero rotates by 32, which returns `reg_val` unchanged with `carry_out` equal to bit 31.
- R10: For every shift by 1 to 31 places, `carry_out` is the last bit shifted out of the value.
- R11: `opd_form` value 3 behaves exactly like form 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_form | input | 2 | Operand form select |
| shift_kind | input | 2 | Shift type for forms 1 to 3 |
| imm_byte | input | 8 | Constant for form 0 |
| rot_field | input | 4 | Half of the rotate amount for form 0 |
| imm_amt | input | 5 | Immediate shift amount for form 1 |
| amt_byte | input | 8 | Low byte of the amount register for form 2 |
| reg_val | input | 32 | Register value to be shifted |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench models each shift as a series of single-bit steps, so the clamps and the meanings of zero are not copied from the design. It covers the zero amounts of every form. A design that treated these as ordinary zero shifts would return the unshifted value for a right shift by 32 and lose the carry fed into bit 31 by the one-bit rotate. It sweeps register amounts across 31, 32, 33 and up to 255. A missing clamp would show up as wrapped amounts, or as a stale bit 0 or bit 31 appearing as the carry after a shift by 33. Rotates whose low five bits are zero would return the wrong carry if they were handled as no shift at all.

// File: rtl/bs_pkg.sv
package bs_pkg;

  localparam int DATA_W  = 32;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int SHAMT_W = 5;
  localparam int RAMT_W  = 8;
  localparam int AMT_W   = SHAMT_W + 1;        // holds 0..33
  localparam int WIDE_W  = 2 * DATA_W + 1;
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] AMT_PAST = AMT_W'(DATA_W + 1);

  typedef enum logic [1:0] {
    FORM_IMM_ROT = 2'd0,
    FORM_IMM_SHF = 2'd1,
    FORM_REG_SHF = 2'd2,
    FORM_REG_ALT = 2'd3
  } opd_form_e;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    shift_kind_e        kind;
    logic [AMT_W-1:0]   amt;
    logic               rrx;
    logic               bypass;
    logic [DATA_W-1:0]  val;
  } shift_req_t;

  // Each function returns {carry, result}.
  function automatic logic [DATA_W:0] f_lsl(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n);
    logic [WIDE_W-1:0] w;
    w = {{(DATA_W+1){1'b0}}, v} << n;
    return {w[DATA_W], w[DATA_W-1:0]};
  endfunction

  function automatic logic [DATA_W:0] f_lsr(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n);
    logic [WIDE_W-1:0] w;
    w = {v, {(DATA_W+1){1'b0}}} >> n;
    return {w[DATA_W], w[WIDE_W-1:DATA_W+1]};
  endfunction

  function automatic logic [DATA_W:0] f_asr(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n);
    logic signed [WIDE_W-1:0] w;
    w = $signed({v, {(DATA_W+1){1'b0}}});
    w = w >>> n;
    return {w[DATA_W], w[WIDE_W-1:DATA_W+1]};
  endfunction

  function automatic logic [DATA_W:0] f_ror(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> n;
    return {d[DATA_W-1], d[DATA_W-1:0]};
  endfunction

  function automatic logic [DATA_W:0] f_rrx(logic [DATA_W-1:0] v, logic c);
    return {v[0], c, v[DATA_W-1:1]};
  endfunction

endpackage

// File: rtl/bs_amount_norm.sv
module bs_amount_norm
  import bs_pkg::*;
(
  input  logic [1:0]          form_i,
  input  logic [1:0]          kind_i,
  input  logic [IMM_W-1:0]    imm_byte_i,
  input  logic [ROT_W-1:0]    rot_field_i,
  input  logic [SHAMT_W-1:0]  imm_amt_i,
  input  logic [RAMT_W-1:0]   amt_byte_i,
  input  logic [DATA_W-1:0]   reg_val_i,
  output shift_req_t          req_o
);

  opd_form_e   form;
  shift_kind_e kind;
  logic        amt_zero_imm;
  logic        amt_zero_reg;
  logic        amt_ge_full;
  logic        amt_ge_past;
  logic [SHAMT_W-1:0] rot_low;

  assign form         = opd_form_e'(form_i);
  assign kind         = shift_kind_e'(kind_i);
  assign amt_zero_imm = (imm_amt_i == '0);
  assign amt_zero_reg = (amt_byte_i == '0);
  assign amt_ge_full  = (amt_byte_i >= RAMT_W'(DATA_W));
  assign amt_ge_past  = (amt_byte_i >= RAMT_W'(DATA_W + 1));
  assign rot_low      = amt_byte_i[SHAMT_W-1:0];

  always_comb begin
    req_o        = '0;
    req_o.kind   = kind;
    req_o.val    = reg_val_i;
    unique case (form)
      FORM_IMM_ROT: begin
        req_o.kind   = SK_ROR;
        req_o.val    = {{(DATA_W-IMM_W){1'b0}}, imm_byte_i};
        req_o.amt    = AMT_W'({rot_field_i, 1'b0});
        req_o.bypass = (rot_field_i == '0);
      end
      FORM_IMM_SHF: begin
        req_o.amt = AMT_W'(imm_amt_i);
        unique case (kind)
          SK_LSL: req_o.bypass = amt_zero_imm;
          SK_LSR,
          SK_ASR: if (amt_zero_imm) req_o.amt = AMT_FULL;
          SK_ROR: req_o.rrx = amt_zero_imm;
          default: ;
        endcase
      end
      default: begin
        req_o.bypass = amt_zero_reg;
        unique case (kind)
          SK_LSL,
          SK_LSR: req_o.amt = amt_ge_past ? AMT_PAST : AMT_W'(amt_byte_i);
          SK_ASR: req_o.amt = amt_ge_full ? AMT_FULL : AMT_W'(amt_byte_i);
          SK_ROR: req_o.amt = (rot_low == '0) ? AMT_FULL : AMT_W'(rot_low);
          default: ;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/bs_shift_core.sv
module bs_shift_core
  import bs_pkg::*;
(
  input  shift_req_t          req_i,
  input  logic                carry_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                carry_o
);

  logic [DATA_W:0] lane [4];
  logic [DATA_W:0] picked;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g == int'(SK_LSL)) begin : g_lsl
      assign lane[g] = f_lsl(req_i.val, req_i.amt);
    end else if (g == int'(SK_LSR)) begin : g_lsr
      assign lane[g] = f_lsr(req_i.val, req_i.amt);
    end else if (g == int'(SK_ASR)) begin : g_asr
      assign lane[g] = f_asr(req_i.val, req_i.amt);
    end else begin : g_ror
      assign lane[g] = f_ror(req_i.val, req_i.amt);
    end
  end

  always_comb begin
    if (req_i.bypass)   picked = {carry_i, req_i.val};
    else if (req_i.rrx) picked = f_rrx(req_i.val, carry_i);
    else                picked = lane[req_i.kind];
  end

  assign result_o = picked[DATA_W-1:0];
  assign carry_o  = picked[DATA_W];

endmodule

// File: rtl/bs_operand_shifter.sv
module bs_operand_shifter
  import bs_pkg::*;
(
  input  logic [1:0]          opd_form,
  input  logic [1:0]          shift_kind,
  input  logic [IMM_W-1:0]    imm_byte,
  input  logic [ROT_W-1:0]    rot_field,
  input  logic [SHAMT_W-1:0]  imm_amt,
  input  logic [RAMT_W-1:0]   amt_byte,
  input  logic [DATA_W-1:0]   reg_val,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   operand,
  output logic                carry_out
);

  shift_req_t        req;
  logic              shift_bypass;
  logic              use_rrx;
  logic [AMT_W-1:0]  eff_amt;

  bs_amount_norm u_norm (
    .form_i      (opd_form),
    .kind_i      (shift_kind),
    .imm_byte_i  (imm_byte),
    .rot_field_i (rot_field),
    .imm_amt_i   (imm_amt),
    .amt_byte_i  (amt_byte),
    .reg_val_i   (reg_val),
    .req_o       (req)
  );

  assign shift_bypass = req.bypass;
  assign use_rrx      = req.rrx;
  assign eff_amt      = req.amt;

  bs_shift_core u_core (
    .req_i    (req),
    .carry_i  (carry_in),
    .result_o (operand),
    .carry_o  (carry_out)
  );

endmodule

// File: rtl/bs_operand_shifter_chk.sv
module bs_operand_shifter_chk
  import bs_pkg::*;
(
  input logic [1:0]          opd_form,
  input logic [1:0]          shift_kind,
  input logic [IMM_W-1:0]    imm_byte,
  input logic [SHAMT_W-1:0]  imm_amt,
  input logic [RAMT_W-1:0]   amt_byte,
  input logic [DATA_W-1:0]   reg_val,
  input logic                carry_in,
  input logic [DATA_W-1:0]   operand,
  input logic                carry_out,
  input logic                shift_bypass,
  input logic                use_rrx,
  input logic [AMT_W-1:0]    eff_amt
);

  logic reg_form;
  assign reg_form = opd_form[1];

  always_comb begin
    if (shift_bypass)
      assert_bypass_keeps_carry_R6: assert (carry_out == carry_in);
    if (opd_form == 2'd0)
      assert_rotate_keeps_ones_R2: assert ($countones(operand) == $countones(imm_byte));
    if (use_rrx)
      assert_rrx_through_carry_R5: assert (operand == {carry_in, reg_val[DATA_W-1:1]}
                                           && carry_out == reg_val[0]);
    assert_amount_bounded_R7: assert (eff_amt <= AMT_W'(DATA_W + 1));
    if (reg_form && !shift_kind[1] && amt_byte > RAMT_W'(DATA_W))
      assert_logical_past_width_R7: assert (operand == '0 && !carry_out);
    if (reg_form && shift_kind == 2'd2 && amt_byte >= RAMT_W'(DATA_W))
      assert_arith_fill_R8: assert (operand == {DATA_W{reg_val[DATA_W-1]}}
                                    && carry_out == reg_val[DATA_W-1]);
    if (opd_form == 2'd1 && shift_kind == 2'd0 && imm_amt == '0)
      assert_lsl_zero_passes_R3: assert (operand == reg_val && carry_out == carry_in);
  end

endmodule

bind bs_operand_shifter bs_operand_shifter_chk u_chk (
  .opd_form     (opd_form),
  .shift_kind   (shift_kind),
  .imm_byte     (imm_byte),
  .imm_amt      (imm_amt),
  .amt_byte     (amt_byte),
  .reg_val      (reg_val),
  .carry_in     (carry_in),
  .operand      (operand),
  .carry_out    (carry_out),
  .shift_bypass (shift_bypass),
  .use_rrx      (use_rrx),
  .eff_amt      (eff_amt)
);

// File: tb/test_bs_operand_shifter.sv
module test_bs_operand_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opd_form = '0;
  logic [1:0]  shift_kind = '0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  rot_field = '0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  amt_byte = '0;
  logic [31:0] reg_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  bs_operand_shifter i_bs_operand_shifter (
    .opd_form   (opd_form),
    .shift_kind (shift_kind),
    .imm_byte   (imm_byte),
    .rot_field  (rot_field),
    .imm_amt    (imm_amt),
    .amt_byte   (amt_byte),
    .reg_val    (reg_val),
    .carry_in   (carry_in),
    .operand    (operand),
    .carry_out  (carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) cycles <= cycles + 1;
    if (rst_n && !done && cycles > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // One step of a shift, carried as {carry, value}.
  function automatic logic [32:0] step1(logic [1:0] k, logic [32:0] cv);
    logic [31:0] v;
    v = cv[31:0];
    case (k)
      2'd0:    return {v[31], v[30:0], 1'b0};
      2'd1:    return {v[0], 1'b0, v[31:1]};
      2'd2:    return {v[0], v[31], v[31:1]};
      default: return {v[0], v[0], v[31:1]};
    endcase
  endfunction

  function automatic logic [32:0] model(logic [1:0] f, logic [1:0] k, logic [7:0] ib,
                                        logic [3:0] rf, logic [4:0] ia, logic [7:0] ab,
                                        logic [31:0] rv, logic ci);
    logic [32:0] x;
    int n;
    x = {ci, rv};
    if (f == 2'd0) begin
      x = {ci, 24'd0, ib};
      n = 2 * int'(rf);
      for (int i = 0; i < n; i++) x = step1(2'd3, x);
    end else if (f == 2'd1) begin
      n = int'(ia);
      if (n == 0 && k == 2'd3) x = {rv[0], ci, rv[31:1]};
      else begin
        if (n == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
        for (int i = 0; i < n; i++) x = step1(k, x);
      end
    end else begin
      n = int'(ab);
      if (n != 0 && k == 2'd3) n = (n % 32 == 0) ? 32 : n % 32;
      for (int i = 0; i < n; i++) x = step1(k, x);
    end
    return x;
  endfunction

  function automatic string tag_of(logic [1:0] f, logic [1:0] k, logic [4:0] ia, logic [7:0] ab);
    if (f == 2'd0) return "R2";
    if (f == 2'd1) begin
      if (ia == 0 && k == 2'd0) return "R3";
      if (ia == 0 && k == 2'd3) return "R5";
      if (ia == 0) return "R4";
      return "R10";
    end
    if (f == 2'd3) return "R11";
    if (ab == 0) return "R6";
    if (k == 2'd3 && ab[4:0] == 0) return "R9";
    if (k == 2'd3) return "R9";
    if (ab >= 32 && k == 2'd2) return "R8";
    if (ab >= 32) return "R7";
    return "R10";
  endfunction

  task automatic run_one(logic [1:0] f, logic [1:0] k, logic [7:0] ib, logic [3:0] rf,
                         logic [4:0] ia, logic [7:0] ab, logic [31:0] rv, logic ci);
    logic [32:0] exp_cv;
    string tag;
    opd_form = f; shift_kind = k; imm_byte = ib; rot_field = rf;
    imm_amt = ia; amt_byte = ab; reg_val = rv; carry_in = ci;
    #2;
    exp_cv = model(f, k, ib, rf, ia, ab, rv, ci);
    tag = tag_of(f, k, ia, ab);
    total = total + 1;
    if (operand !== exp_cv[31:0] || carry_out !== exp_cv[32]) begin
      bad = bad + 1;
      $display("FAIL %s form=%0d kind=%0d ib=%h rf=%0d ia=%0d ab=%0d rv=%h ci=%b: actual=%b_%h expected=%b_%h",
               tag, f, k, ib, rf, ia, ab, rv, ci, carry_out, operand, exp_cv[32], exp_cv[31:0]);
    end
    #1;
  endtask

  logic [31:0] pats [6];

  initial begin
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0000;
    pats[3] = 32'h1234_5678; pats[4] = 32'h7FFF_FFFE; pats[5] = 32'hC3A5_0F96;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle inputs (form 0, rotate field 0, carry 0) give zero operand and carry.
    total = total + 1;
    if (operand !== 32'd0 || carry_out !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R1 idle: actual=%b_%h expected=0_00000000", carry_out, operand);
    end

    // R2: every constant with every rotate field.
    for (int b = 0; b < 256; b++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 2; c++)
          run_one(2'd0, 2'd0, 8'(b), 4'(r), 5'd0, 8'd0, 32'd0, 1'(c));

    // R1, R3, R4, R5, R10: immediate amounts across all kinds.
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 32; a++)
          for (int c = 0; c < 2; c++)
            run_one(2'd1, 2'(k), 8'hA5, 4'd3, 5'(a), 8'd0, pats[p], 1'(c));

    // R6, R7, R8, R9, R10: register amounts over the full byte.
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          for (int c = 0; c < 2; c++)
            run_one(2'd2, 2'(k), 8'h5A, 4'd7, 5'd9, 8'(a), pats[p], 1'(c));

    // R11: form code 3 mirrors form 2.
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 70; a++)
        for (int c = 0; c < 2; c++)
          run_one(2'd3, 2'(k), 8'h0F, 4'd1, 5'd0, 8'(a), pats[5], 1'(c));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule